// File: doc/BRIEF.md
# Load-Mode Front-Panel DMA Controller

This block reproduces how a small trainer board's front panel deposits bytes into memory while the processor sits in its load state. A pointer register selects the next address to fill. As long as load mode is selected and the operator is not pressing the input button, the block keeps running memory read cycles at the address one below the pointer. It throws those bytes away except for one use: it latches them into a two-digit hex display register.

Each press of the input button starts exactly one DMA cycle at the pointer address and then advances the pointer. The DMA cycle writes the data switches to memory only when memory protect is off. The display never takes its value from the write itself, so it always shows the byte just below the next free address. With protect on, repeated presses therefore walk through memory and show what is already stored there.

A parameter selects a minimal-memory build in which only the low address byte reaches the bus.

Top module: `loadpanel_dma`

## Requirements
- R1: After reset the display register reads 00, and neither the memory read strobe nor the write strobe is active.
- R2: In load mode, in every cycle without a DMA cycle, the block asserts the read strobe with the write strobe low, and the address is the pointer minus one, wrapping at the address width.
- R3: The display loads the read data only in the cycle that follows an idle read. The read data arrives one clock after the address. A DMA cycle never loads the display, so after each press the display settles to the memory byte at the new pointer minus one.
- R4: On entry to load mode the pointer is zero, so the first idle read address and the displayed byte come from the all-ones address (FFFF for 16 bits).
- R5: When the minimal-memory parameter is set, the address bits above bit 7 are driven to zero, so the first idle read on entry uses address 00FF.
- R6: A press in load mode produces a single DMA cycle. In that cycle the read strobe is low, the address is the pointer, and the write data equals the switches. The pointer increments by one at the end of the cycle.
- R7: With memory protect on, the write strobe stays low during the DMA cycle and memory is left unchanged, but the pointer still advances.
- R8: The pointer wraps from its all-ones value to zero.
- R9: Outside load mode both strobes are low, the display holds its value, and the pointer is cleared, so the next entry starts at zero.
- R10: A button press while load mode is off starts no memory cycle.
- R11: The button input is synchronised and edge-detected. Holding it down for many cycles gives exactly one DMA cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_mode | input | 1 | Load-mode switch, synchronous to clk |
| mem_protect | input | 1 | Memory-protect switch, synchronous to clk |
| btn_in | input | 1 | Raw input button, asynchronous |
| sw_data | input | 8 | Data switches |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe (idle read) |
| mem_wr | output | 1 | Write strobe (DMA deposit) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| disp | output | 8 | Hex display latch |

## Verification
The assertions assume that load_mode and mem_protect change only in step with the clock. They also assume that memory returns read data exactly one clock after a read address. The bench meets both conditions: it drives every input one time unit after a rising edge, and its memory model registers the read data on the edge that samples the address. The button is the only input treated as asynchronous. The bench holds it for anywhere from one to many cycles and leaves quiet gaps between presses, so each press is seen as a separate edge.

// File: rtl/loadpanel_pkg.sv
package loadpanel_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } btn_state_t;

    typedef struct packed {
        logic              rdv;
        logic [DATA_W-1:0] val;
    } disp_state_t;

endpackage

// File: rtl/loadpanel_btn.sv
module loadpanel_btn (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    import loadpanel_pkg::*;

    btn_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = btn_raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign press = st_q.s2 & ~st_q.s3;

    // R11
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

endmodule

// File: rtl/loadpanel_seq.sv
module loadpanel_seq #(
    parameter int ADDR_W  = 16,
    parameter bit MIN_MEM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mode,
    input  logic              mem_protect,
    input  logic              press,
    input  logic [7:0]        sw_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata
);
    localparam int LOW_W = 8;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic              dma;
    logic [ADDR_W-1:0] raw_addr;

    always_comb begin
        st_d     = st_q;
        dma      = load_mode & press;
        raw_addr = dma ? st_q.ptr : (st_q.ptr - ONE);
        if (!load_mode)
            st_d.ptr = '0;
        else if (dma)
            st_d.ptr = st_q.ptr + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (MIN_MEM && (ADDR_W > LOW_W)) begin : g_min
            assign mem_addr = {{(ADDR_W-LOW_W){1'b0}}, raw_addr[LOW_W-1:0]};
        end else begin : g_full
            assign mem_addr = raw_addr;
        end
    endgenerate

    assign mem_rd    = load_mode & ~press;
    assign mem_wr    = dma & ~mem_protect;
    assign mem_wdata = sw_data;

    // R2
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !mem_wr);
    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode && press) |=> st_q.ptr == $past(st_q.ptr) + ONE);
    // R7
    protect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_protect |-> !mem_wr);
    // R9
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_mode |=> st_q.ptr == '0);

endmodule

// File: rtl/loadpanel_disp.sv
module loadpanel_disp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_issued,
    input  logic [7:0] rdata,
    output logic [7:0] disp
);
    import loadpanel_pkg::*;

    disp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rdv = rd_issued;
        if (st_q.rdv)
            st_d.val = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp = st_q.val;

    // R3
    disp_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.val != $past(st_q.val)) |-> $past(st_q.rdv));

endmodule

// File: rtl/loadpanel_dma.sv
module loadpanel_dma #(
    parameter int ADDR_W  = 16,
    parameter bit MIN_MEM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mode,
    input  logic              mem_protect,
    input  logic              btn_in,
    input  logic [7:0]        sw_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        disp
);
    logic press;

    loadpanel_btn u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (btn_in),
        .press   (press)
    );

    loadpanel_seq #(.ADDR_W(ADDR_W), .MIN_MEM(MIN_MEM)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_mode   (load_mode),
        .mem_protect (mem_protect),
        .press       (press),
        .sw_data     (sw_data),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_wdata   (mem_wdata)
    );

    loadpanel_disp u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issued (mem_rd),
        .rdata     (mem_rdata),
        .disp      (disp)
    );

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_mode |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/tb_loadpanel_dma.sv
module tb_loadpanel_dma;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_mode = 1'b0;
    logic mem_protect = 1'b0;
    logic btn_in = 1'b0;
    logic [7:0] sw_data = 8'h00;

    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata, disp;

    logic [15:0] min_addr;
    logic        min_rd, min_wr;
    logic [7:0]  min_wdata, min_rdata, min_disp;

    logic [3:0]  w_addr;
    logic        w_rd, w_wr;
    logic [7:0]  w_wdata, w_rdata, w_disp;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit outside_activity = 1'b0;

    byte unsigned overlay [int];

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        we;
        string       req;
    } dma_item_t;
    dma_item_t exp_q [$];

    logic [15:0] exp_ptr = 16'h0000;

    always #(CLK_NS/2) clk = ~clk;

    loadpanel_dma #(.ADDR_W(16), .MIN_MEM(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .mem_protect(mem_protect),
        .btn_in(btn_in), .sw_data(sw_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .disp(disp)
    );

    loadpanel_dma #(.ADDR_W(16), .MIN_MEM(1'b1)) dut_min (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .mem_protect(1'b1),
        .btn_in(btn_in), .sw_data(sw_data), .mem_addr(min_addr), .mem_rd(min_rd),
        .mem_wr(min_wr), .mem_wdata(min_wdata), .mem_rdata(min_rdata), .disp(min_disp)
    );

    loadpanel_dma #(.ADDR_W(4), .MIN_MEM(1'b0)) dut_w (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .mem_protect(1'b1),
        .btn_in(btn_in), .sw_data(sw_data), .mem_addr(w_addr), .mem_rd(w_rd),
        .mem_wr(w_wr), .mem_wdata(w_wdata), .mem_rdata(w_rdata), .disp(w_disp)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        if (overlay.exists(int'(a))) return overlay[int'(a)];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (mem_wr) overlay[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= mem_val(mem_addr);
        if (min_rd) min_rdata <= pat(min_addr);
        if (w_rd)   w_rdata   <= pat({12'h000, w_addr});
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: every DMA cycle of the main instance pops an expected item
    always @(negedge clk) begin
        if (rst_n && !load_mode && (mem_rd || mem_wr)) outside_activity = 1'b1;
        if (rst_n && load_mode && !mem_rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected DMA cycle at", mem_addr, 16'hxxxx);
            end else begin
                dma_item_t it;
                it = exp_q.pop_front();
                check(mem_addr == it.addr, it.req, "DMA addr", mem_addr, it.addr);
                check(mem_wr == it.we, it.req, "write strobe", {15'b0, mem_wr}, {15'b0, it.we});
                check(mem_wdata == it.data, "R6", "write data", {8'h00, mem_wdata}, {8'h00, it.data});
                // R8: narrow instance wraps its pointer at 4 bits
                check(w_addr == it.addr[3:0], "R8", "narrow DMA addr",
                      {12'h000, w_addr}, {12'h000, it.addr[3:0]});
            end
        end
    end

    task automatic press(input logic [7:0] sw, input int hold, input string req);
        @(posedge clk) #1;
        sw_data = sw;
        btn_in  = 1'b1;
        if (load_mode) begin
            dma_item_t it;
            it.addr = exp_ptr;
            it.data = sw;
            it.we   = ~mem_protect;
            it.req  = req;
            exp_q.push_back(it);
            exp_ptr = exp_ptr + 16'h1;
        end
        repeat (hold) @(posedge clk);
        #1 btn_in = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(disp == 8'h00, "R1", "display after reset", {8'h00, disp}, 16'h0000);
        check(!mem_rd && !mem_wr, "R1", "strobes after reset", {14'b0, mem_rd, mem_wr}, 16'h0000);
        @(posedge clk) #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!mem_rd && !mem_wr, "R1", "strobes out of reset", {14'b0, mem_rd, mem_wr}, 16'h0000);

        // Enter load mode
        @(posedge clk) #1 load_mode = 1'b1;
        mem_protect = 1'b1;
        exp_ptr = 16'h0000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_rd && !mem_wr, "R2", "idle read strobes", {14'b0, mem_rd, mem_wr}, 16'h0002);
        check(mem_addr == 16'hFFFF, "R2", "idle read addr", mem_addr, 16'hFFFF);
        check(disp == pat(16'hFFFF), "R4", "entry display", {8'h00, disp}, {8'h00, pat(16'hFFFF)});
        check(min_addr == 16'h00FF, "R5", "minimal idle addr", min_addr, 16'h00FF);
        check(min_disp == pat(16'h00FF), "R5", "minimal entry display",
              {8'h00, min_disp}, {8'h00, pat(16'h00FF)});
        check(w_addr == 4'hF, "R8", "narrow entry addr", {12'h000, w_addr}, 16'h000F);

        // Protected presses step through existing memory
        for (int i = 0; i < 3; i++) begin
            press(8'hAA, 1, "R7");
            check(disp == pat(16'(i)), "R7", "protected step display",
                  {8'h00, disp}, {8'h00, pat(16'(i))});
            check(mem_addr == 16'(i), "R2", "idle addr after step", mem_addr, 16'(i));
        end
        check(!overlay.exists(0) && !overlay.exists(1) && !overlay.exists(2), "R7",
              "memory written under protect", 16'h0001, 16'h0000);

        // Unprotected deposits; display shows the byte just written
        @(posedge clk) #1 mem_protect = 1'b0;
        press(8'h3C, 2, "R6");
        check(disp == 8'h3C, "R3", "display after write", {8'h00, disp}, 16'h003C);
        press(8'hC5, 3, "R6");
        check(disp == 8'hC5, "R3", "display after second write", {8'h00, disp}, 16'h00C5);

        // Long hold yields one DMA cycle only
        press(8'h11, 25, "R11");
        check(exp_q.size() == 0, "R11", "pending DMA items", 16'(exp_q.size()), 16'h0000);
        check(mem_addr == 16'h0005, "R11", "idle addr after long hold", mem_addr, 16'h0005);
        check(disp == 8'h11, "R3", "display after long hold", {8'h00, disp}, 16'h0011);

        // Leave load mode: bus idle, display holds, button ignored
        @(posedge clk) #1 load_mode = 1'b0;
        outside_activity = 1'b0;
        press(8'hEE, 2, "R10");
        check(!outside_activity, "R10", "bus activity outside load mode", 16'h0001, 16'h0000);
        check(disp == 8'h11, "R9", "display held outside load", {8'h00, disp}, 16'h0011);
        check(!overlay.exists(6), "R10", "write outside load mode", 16'h0001, 16'h0000);

        // Re-enter: pointer restarts at zero
        @(posedge clk) #1 load_mode = 1'b1;
        mem_protect = 1'b1;
        exp_ptr = 16'h0000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_addr == 16'hFFFF, "R9", "idle addr on re-entry", mem_addr, 16'hFFFF);
        check(disp == pat(16'hFFFF), "R4", "display on re-entry", {8'h00, disp}, {8'h00, pat(16'hFFFF)});
        press(8'h00, 1, "R9");
        check(disp == 8'h96, "R9", "display after first press on re-entry", {8'h00, disp}, 16'h0096);

        // Narrow instance wraps after 16 presses
        for (int i = 0; i < 16; i++) press(8'h5A, 1, "R8");
        @(negedge clk);
        check(w_addr == 4'h0, "R8", "narrow idle addr after wrap", {12'h000, w_addr}, 16'h0000);
        check(exp_q.size() == 0, "R6", "pending DMA items", 16'(exp_q.size()), 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule